// File: doc/BRIEF.md
# Per-Module Stop Request Controller

This block manages power for a group of modules. Each module has its own stop state, and software controls it through a single halt register. Writing a 1 into a module's bit raises that module's stop request. The block withdraws that module's clock enable only after the module answers with an acknowledge. Writing the bit back to 0 withdraws the request, and the clock enable returns one cycle later.

Channel 0 serves the processor core and follows a stricter rule. Its request is raised only when its halt bit is set and the core signals that it has executed a wait instruction. Any interrupt line cancels the request. The core then stays awake until it issues another wait strobe while its bit is still set. A status vector shows which channels are clock-gated at present.

Top module: `stop_req_ctrl`

## Requirements
- R1: After reset the halt register reads 0, every stop request is 0, every clock enable is 1 and the gated status is 0.
- R2: When wr_en is high at a clock edge, wr_data replaces the halt register, and rd_data returns the new value from that edge onward.
- R3: For every channel other than 0, stop_req follows the halt register bit of that channel, changing on the edge that writes the register.
- R4: A channel's clock enable goes low on the edge after the one where its stop request and its acknowledge are both sampled high. While the acknowledge stays low, the clock enable stays high.
- R5: Once a channel is gated, dropping its acknowledge while the request is still active leaves the clock enable low.
- R6: If a channel's stop request is sampled low at an edge, that channel's clock enable is high after that edge. A cleared halt bit therefore restores the clock on the edge after the write.
- R7: Channel 0 raises no stop request while its halt bit is 0, even when the wait strobe or the acknowledge is high.
- R8: A wait strobe sampled with halt bit 0 set and no interrupt active raises stop_req[0] on that same edge.
- R9: Any bit of irq sampled high clears stop_req[0] on that edge, and this takes priority over a wait strobe in the same cycle. The core clock enable then returns on the following edge.
- R10: After an interrupt wake, stop_req[0] stays low until a new wait strobe arrives while halt bit 0 is still set.
- R11: gated[i] is the inverse of clk_en[i] on every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Halt register write strobe |
| wr_data | input | NUM_CH | Value written to the halt register |
| rd_data | output | NUM_CH | Current halt register contents |
| stop_ack | input | NUM_CH | Per-module acknowledge of its stop request |
| wait_strobe | input | 1 | Core has executed a wait instruction |
| irq | input | NUM_IRQ | Interrupt request lines that wake the core |
| stop_req | output | NUM_CH | Per-module stop request |
| clk_en | output | NUM_CH | Per-module registered clock enable |
| gated | output | NUM_CH | 1 where a module's clock is currently withheld |

## Verification
Three rules are checked by the assertions on every cycle. The first is the handshake: gating requires a sampled request with its acknowledge, gating holds while the request stays active, and the clock returns once the request is gone. The second is the core wake rule, where an interrupt or a cleared bit ends the core request and a wait strobe with the bit set starts it. The third is that register writes land. Some properties only the bench's scenarios can show. These are the exact cycle-by-cycle sequence over several channels, that the core stays awake after an interrupt until the next strobe, that the status matches the clock enables, and that a reset during gating restores every clock.

// File: rtl/stop_ctrl_pkg.sv
package stop_ctrl_pkg;
  // Channel index reserved for the processor core.
  localparam int unsigned CORE_IDX = 0;

  typedef enum logic {
    CH_RUNNING = 1'b0,
    CH_GATED   = 1'b1
  } ch_state_e;
endpackage

// File: rtl/halt_reg.sv
module halt_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] halt_q
);
  logic [WIDTH-1:0] halt_d;

  always_comb begin
    halt_d = halt_q;
    if (wr_en) halt_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= '0;
    else        halt_q <= halt_d;
  end

  // R2: a write lands in the register by the next edge
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (halt_q == $past(wr_data)));
endmodule

// File: rtl/core_wait_ctl.sv
module core_wait_ctl #(
  parameter int unsigned NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_bit,
  input  logic               wait_strobe,
  input  logic [NUM_IRQ-1:0] irq,
  output logic               core_req
);
  logic sleep_q, sleep_d;
  logic irq_any;

  assign irq_any = |irq;

  always_comb begin
    sleep_d = sleep_q;
    if (irq_any)          sleep_d = 1'b0;
    else if (!halt_bit)   sleep_d = 1'b0;
    else if (wait_strobe) sleep_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b0;
    else        sleep_q <= sleep_d;
  end

  assign core_req = sleep_q & halt_bit;

  // R9: any interrupt ends the core's sleep request
  assert_irq_wakes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |=> !sleep_q);
  // R7: no sleep without the halt bit
  assert_bit_needed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_bit |=> !sleep_q);
  // R8: a wait strobe with the bit set and no interrupt starts sleep
  assert_wait_sleeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_strobe && halt_bit && !irq_any) |=> sleep_q);
  // R10: awake core stays awake without a new strobe
  assert_stay_awake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_q && !wait_strobe) |=> !sleep_q);
endmodule

// File: rtl/stop_channel.sv
module stop_channel
  import stop_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ack_i,
  output logic gated_o
);
  ch_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!req_i)     state_d = CH_RUNNING;
    else if (ack_i) state_d = CH_GATED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CH_RUNNING;
    else        state_q <= state_d;
  end

  assign gated_o = (state_q == CH_GATED);

  // R4: gating only follows a sampled request with acknowledge
  assert_gate_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gated_o && !(req_i && ack_i)) |=> !gated_o);
  assert_ack_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && ack_i) |=> gated_o);
  // R5: gated channel stays gated while the request holds
  assert_hold_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_o && req_i) |=> gated_o);
  // R6: withdrawn request restores the clock
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !gated_o);
endmodule

// File: rtl/stop_req_ctrl.sv
module stop_req_ctrl
  import stop_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_CH-1:0]  wr_data,
  output logic [NUM_CH-1:0]  rd_data,
  input  logic [NUM_CH-1:0]  stop_ack,
  input  logic               wait_strobe,
  input  logic [NUM_IRQ-1:0] irq,
  output logic [NUM_CH-1:0]  stop_req,
  output logic [NUM_CH-1:0]  clk_en,
  output logic [NUM_CH-1:0]  gated
);
  logic [NUM_CH-1:0] halt_q;
  logic              core_req;

  halt_reg #(.WIDTH(NUM_CH)) u_halt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .halt_q  (halt_q)
  );

  core_wait_ctl #(.NUM_IRQ(NUM_IRQ)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_bit    (halt_q[CORE_IDX]),
    .wait_strobe (wait_strobe),
    .irq         (irq),
    .core_req    (core_req)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i == CORE_IDX) begin : g_core
      assign stop_req[i] = core_req;
    end else begin : g_mod
      assign stop_req[i] = halt_q[i];
    end

    stop_channel u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (stop_req[i]),
      .ack_i   (stop_ack[i]),
      .gated_o (gated[i])
    );
  end

  assign clk_en  = ~gated;
  assign rd_data = halt_q;

  // R3: peripheral requests never exceed the halt bits
  assert_req_within_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req & ~halt_q) == '0);
endmodule

// File: tb/stop_req_ctrl_test.sv
module stop_req_ctrl_test;
  localparam int NCH = 8;
  localparam int NIRQ = 4;

  typedef struct packed {
    logic            wr;
    logic [NCH-1:0]  data;
    logic [NCH-1:0]  ack;
    logic            wstb;
    logic [NIRQ-1:0] irq;
    logic [NCH-1:0]  exp_req;
    logic [NCH-1:0]  exp_en;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 8'h06, 8'h00, 1'b0, 4'h0, 8'h06, 8'hFF}, // 0  R3 R4: request, no ack
    '{1'b0, 8'h00, 8'h02, 1'b0, 4'h0, 8'h06, 8'hFD}, // 1  R4: ch1 acks
    '{1'b0, 8'h00, 8'h06, 1'b0, 4'h0, 8'h06, 8'hF9}, // 2  R4: ch2 acks
    '{1'b0, 8'h00, 8'h00, 1'b0, 4'h0, 8'h06, 8'hF9}, // 3  R5: ack drops
    '{1'b1, 8'h04, 8'h00, 1'b0, 4'h0, 8'h04, 8'hF9}, // 4  R6: clear ch1
    '{1'b0, 8'h00, 8'h00, 1'b0, 4'h0, 8'h04, 8'hFB}, // 5  R6: ch1 clock back
    '{1'b1, 8'h05, 8'h00, 1'b0, 4'h0, 8'h04, 8'hFB}, // 6  R7: core bit alone
    '{1'b0, 8'h00, 8'h01, 1'b0, 4'h0, 8'h04, 8'hFB}, // 7  R7: ack without wait
    '{1'b0, 8'h00, 8'h01, 1'b1, 4'h0, 8'h05, 8'hFB}, // 8  R8: wait strobe
    '{1'b0, 8'h00, 8'h01, 1'b0, 4'h0, 8'h05, 8'hFA}, // 9  R4: core gated
    '{1'b0, 8'h00, 8'h01, 1'b0, 4'h4, 8'h04, 8'hFA}, // 10 R9: interrupt
    '{1'b0, 8'h00, 8'h01, 1'b0, 4'h0, 8'h04, 8'hFB}, // 11 R9: core clock back
    '{1'b0, 8'h00, 8'h01, 1'b0, 4'h0, 8'h04, 8'hFB}, // 12 R10: stays awake
    '{1'b0, 8'h00, 8'h01, 1'b1, 4'h1, 8'h04, 8'hFB}, // 13 R9: irq beats wait
    '{1'b1, 8'h04, 8'h01, 1'b0, 4'h0, 8'h04, 8'hFB}, // 14 clear core bit
    '{1'b0, 8'h00, 8'h01, 1'b1, 4'h0, 8'h04, 8'hFB}, // 15 R7: wait ignored
    '{1'b1, 8'h00, 8'h00, 1'b0, 4'h0, 8'h00, 8'hFB}, // 16 R6: clear all
    '{1'b0, 8'h00, 8'h00, 1'b0, 4'h0, 8'h00, 8'hFF}  // 17 R6: all running
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en, wait_strobe;
  logic [NCH-1:0]  wr_data, rd_data, stop_ack, stop_req, clk_en, gated;
  logic [NIRQ-1:0] irq;
  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  stop_req_ctrl #(.NUM_CH(NCH), .NUM_IRQ(NIRQ)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .stop_ack(stop_ack), .wait_strobe(wait_strobe),
    .irq(irq), .stop_req(stop_req), .clk_en(clk_en), .gated(gated)
  );

  task automatic check(input string tag, input logic [NCH-1:0] act,
                       input logic [NCH-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_data = '0; stop_ack = '0; wait_strobe = 1'b0; irq = '0;
  endtask

  initial begin
    #200000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    #9;
    // R1: reset state
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 stop_req", stop_req, 8'h00);
    check("R1 clk_en", clk_en, 8'hFF);
    check("R1 gated", gated, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      wr_en = TBL[v].wr; wr_data = TBL[v].data; stop_ack = TBL[v].ack;
      wait_strobe = TBL[v].wstb; irq = TBL[v].irq;
      @(negedge clk);
      check($sformatf("R3/R7-R10 req vec %0d", v), stop_req, TBL[v].exp_req);
      check($sformatf("R4-R6 clk_en vec %0d", v), clk_en, TBL[v].exp_en);
      check($sformatf("R11 gated vec %0d", v), gated, ~TBL[v].exp_en);
    end
    idle_inputs();

    // R2: write then read back
    wr_en = 1'b1; wr_data = 8'hA4;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
    check("R2 rd_data", rd_data, 8'hA4);
    @(negedge clk);
    check("R2 rd_data held", rd_data, 8'hA4);

    // R1: reset while modules are gated
    stop_ack = 8'hFF;
    @(negedge clk);
    check("R4 gated before reset", clk_en, 8'h5B);
    rst_n = 1'b0;
    #1;
    check("R1 reset clk_en", clk_en, 8'hFF);
    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 reset stop_req", stop_req, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    idle_inputs();
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule